// File: doc/BRIEF.md
# Field-Policy Control/Status Register

This block is a single memory-mapped control/status word built from a set of fields. Each field has an access policy that fixes two things: what a bus read returns, and what a bus write does to it. There are two ordinary kinds, read/write and peripheral-owned read-only. There are also three reserved kinds:
- read-as-zero, where writes are ignored;
- must-write-zero;
- write-back-what-you-read.

Each of the two write-constrained reserved kinds can be built either with real storage or as a stateless constant. The read/write policy is therefore separate from whether any state sits behind it.

The bus side always reads or writes the whole word as one atomic unit. A single write strobe updates every bus-writable field in that cycle. A read strobe returns the word one clock later.

The peripheral side owns a per-bit write mask and write data. It can change any subset of the stored bits in any cycle, and it wins over a bus write on the bits it touches.

Setting the `ALIAS` parameter turns the address into a split pair. Reads return a status word driven by the peripheral. Writes leave the fields alone and instead emit a one-cycle command pulse carrying the written word.

Top module: `csr_policy_reg`

## Requirements
- R1: After reset `reg_q_o` and a bus read both return the reset word; with default parameters this is 0x096003A5.
- R2: One bus write updates every bus-writable field in the same cycle. With default parameters these are bits 7:0 (read/write), 19:16 (storing must-write-zero) and 23:20 (storing write-back). All of them show on `reg_q_o` after that clock edge.
- R3: The read-only field (bits 11:8 by default) ignores bus writes and changes only through peripheral masked writes.
- R4: The read-as-zero field (bits 15:12 by default) always reads 0. Bus and peripheral writes have no effect on it.
- R5: A storing must-write-zero field (19:16) keeps the value written to it. The stateless must-write-zero field (31:28) always reads 0.
- R6: A storing write-back field (23:20) keeps the value written to it. The stateless write-back field (27:24) always reads its reset value (9 by default) and ignores writes.
- R7: A peripheral write changes exactly the stored bits whose mask bit is 1, to the matching write-data bits. All other bits keep their value.
- R8: When a bus write and a peripheral write hit the same bit in one cycle, the peripheral value lands in that bit. The bus value still lands in every other bus-writable bit.
- R9: A read strobe is followed one clock later by a one-cycle `bus_rvalid_o`. The data returned is the word as it was in the strobe cycle, even if a write occurs in that same cycle.
- R10: With `ALIAS`=1, each bus write produces a one-cycle `cmd_valid_o` on the next clock, with `cmd_data_o` equal to the written word. The fields are not changed by the bus write.
- R11: With `ALIAS`=1, a bus read returns the value of `sts_i` from the strobe cycle, never the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Single-cycle whole-word write strobe |
| bus_rd_i | input | 1 | Single-cycle read strobe |
| bus_wdata_i | input | DW | Bus write word |
| bus_rdata_o | output | DW | Read word, valid with `bus_rvalid_o` |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the strobe |
| per_wmask_i | input | DW | Peripheral per-bit write enable |
| per_wdata_i | input | DW | Peripheral write data |
| reg_q_o | output | DW | Current field view of the register |
| sts_i | input | DW | Status word read in aliased mode |
| cmd_valid_o | output | 1 | Command pulse in aliased mode |
| cmd_data_o | output | DW | Command word in aliased mode |

## Verification
The bus write and the peripheral masked write can land in the same cycle. The bench provokes this by raising the write strobe together with a mask that overlaps a bus-writable field. It then judges every nibble of `reg_q_o`: the overlapped bits must carry the peripheral value, and the rest of the word must carry the bus value.

A read strobe can also fall in the same cycle as a write. The bench checks that the returned word is the pre-write value while `reg_q_o` already shows the new one.

// File: rtl/csr_pol_pkg.sv
package csr_pol_pkg;

  typedef enum logic [2:0] {
    POL_RW     = 3'd0,
    POL_RO     = 3'd1,
    POL_RAZ    = 3'd2,
    POL_RSV_W0 = 3'd3,
    POL_RSV_WL = 3'd4
  } pol_e;

  function automatic bit bus_can_write(pol_e p, bit store);
    return (p == POL_RW) || (store && ((p == POL_RSV_W0) || (p == POL_RSV_WL)));
  endfunction

  function automatic bit per_can_write(pol_e p, bit store);
    return (p == POL_RW) || (p == POL_RO) ||
           (store && ((p == POL_RSV_W0) || (p == POL_RSV_WL)));
  endfunction

endpackage

// File: rtl/csr_field.sv
module csr_field
  import csr_pol_pkg::*;
#(
  parameter int unsigned W     = 4,
  parameter pol_e        POL   = POL_RW,
  parameter bit          STORE = 1'b1,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic [W-1:0] bus_wd,
  input  logic [W-1:0] per_mask,
  input  logic [W-1:0] per_wd,
  output logic [W-1:0] view
);

  localparam bit BUS_OK = bus_can_write(POL, STORE);
  localparam bit PER_OK = per_can_write(POL, STORE);

  logic unused_inputs;
  assign unused_inputs = ^{bus_we, bus_wd, per_mask, per_wd, clk, rst_n};

  generate
    if (PER_OK) begin : g_store
      logic [W-1:0] q;
      logic [W-1:0] q_nxt;
      logic         q_en;
      logic         bus_hit;

      assign bus_hit = BUS_OK && bus_we;

      always_comb begin
        q_nxt = q;
        if (bus_hit) q_nxt = bus_wd;
        q_nxt = (q_nxt & ~per_mask) | (per_wd & per_mask);
        q_en  = bus_hit || (|per_mask);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= RST;
        else if (q_en) q <= q_nxt;
      end

      assign view = q;
    end else begin : g_const
      localparam logic [W-1:0] CONST_V = (POL == POL_RSV_WL) ? RST : '0;
      assign view = CONST_V;
    end
  endgenerate

endmodule

// File: rtl/csr_rd_port.sv
module csr_rd_port #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic [DW-1:0] src,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  logic [DW-1:0] rdata_nxt;
  logic          rvalid_nxt;

  always_comb begin
    rvalid_nxt = rd_stb;
    rdata_nxt  = src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rvalid_nxt;
      if (rd_stb) rdata <= rdata_nxt;
    end
  end

endmodule

// File: rtl/csr_cmd_port.sv
module csr_cmd_port #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wdata,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_data
);

  logic valid_nxt;

  always_comb valid_nxt = wr_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= valid_nxt;
      if (wr_stb) cmd_data <= wdata;
    end
  end

endmodule

// File: rtl/csr_policy_reg.sv
module csr_policy_reg
  import csr_pol_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned NF     = 7,
  parameter int unsigned FLD_LSB [NF] = '{0, 8, 12, 16, 20, 24, 28},
  parameter int unsigned FLD_WID [NF] = '{8, 4, 4, 4, 4, 4, 4},
  parameter pol_e        FLD_POL [NF] = '{POL_RW, POL_RO, POL_RAZ, POL_RSV_W0,
                                          POL_RSV_WL, POL_RSV_WL, POL_RSV_W0},
  parameter logic [NF-1:0] FLD_STORE = 7'b0011011,
  parameter logic [DW-1:0] RST_WORD  = 32'h096003A5,
  parameter bit          ALIAS  = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          bus_rvalid_o,
  input  logic [DW-1:0] per_wmask_i,
  input  logic [DW-1:0] per_wdata_i,
  output logic [DW-1:0] reg_q_o,
  input  logic [DW-1:0] sts_i,
  output logic          cmd_valid_o,
  output logic [DW-1:0] cmd_data_o
);

  logic [DW-1:0] view_w;
  logic [DW-1:0] raz_mask;
  logic [DW-1:0] ro_mask;
  logic [DW-1:0] rd_src;
  logic          field_we;

  // Field array: one policy slice per entry of the parameter tables.
  generate
    for (genvar f = 0; f < NF; f++) begin : g_fld
      localparam int unsigned L = FLD_LSB[f];
      localparam int unsigned W = FLD_WID[f];

      csr_field #(
        .W     (W),
        .POL   (FLD_POL[f]),
        .STORE (FLD_STORE[f]),
        .RST   (RST_WORD[L +: W])
      ) u_fld (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (field_we),
        .bus_wd   (bus_wdata_i[L +: W]),
        .per_mask (per_wmask_i[L +: W]),
        .per_wd   (per_wdata_i[L +: W]),
        .view     (view_w[L +: W])
      );

      assign raz_mask[L +: W] = {W{FLD_POL[f] == POL_RAZ}};
      assign ro_mask[L +: W]  = {W{FLD_POL[f] == POL_RO}};
    end
  endgenerate

  assign reg_q_o = view_w;

  // Mode select: plain register or split status/command pair.
  generate
    if (ALIAS) begin : g_alias
      assign field_we = 1'b0;
      assign rd_src   = sts_i;

      csr_cmd_port #(.DW(DW)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (bus_wr_i),
        .wdata     (bus_wdata_i),
        .cmd_valid (cmd_valid_o),
        .cmd_data  (cmd_data_o)
      );
    end else begin : g_plain
      logic unused_sts;
      assign unused_sts  = ^sts_i;
      assign field_we    = bus_wr_i;
      assign rd_src      = view_w;
      assign cmd_valid_o = 1'b0;
      assign cmd_data_o  = '0;
    end
  endgenerate

  csr_rd_port #(.DW(DW)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_stb (bus_rd_i),
    .src    (rd_src),
    .rdata  (bus_rdata_o),
    .rvalid (bus_rvalid_o)
  );

endmodule

// File: rtl/csr_policy_reg_chk.sv
module csr_policy_reg_chk #(
  parameter int unsigned DW    = 32,
  parameter bit          ALIAS = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] rdata,
  input logic          rvalid,
  input logic [DW-1:0] per_wmask,
  input logic [DW-1:0] reg_q,
  input logic [DW-1:0] sts,
  input logic          cmd_valid,
  input logic [DW-1:0] cmd_data,
  input logic [DW-1:0] raz_mask,
  input logic [DW-1:0] ro_mask
);

  assert_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rvalid);

  assert_rvalid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !rvalid);

  assert_raz_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q & raz_mask) == '0);

  assert_ro_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((per_wmask & ro_mask) == '0) |=> ((reg_q & ro_mask) == ($past(reg_q) & ro_mask)));

  assert_per_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr || ALIAS) |=> (((reg_q ^ $past(reg_q)) & ~$past(per_wmask)) == '0));

  generate
    if (ALIAS) begin : g_alias_chk
      assert_cmd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (cmd_valid && (cmd_data == $past(bus_wdata))));

      assert_cmd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> !cmd_valid);

      assert_fields_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (per_wmask == '0) |=> $stable(reg_q));

      assert_sts_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (rdata == $past(sts)));
    end
  endgenerate

endmodule

bind csr_policy_reg csr_policy_reg_chk #(.DW(DW), .ALIAS(ALIAS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr_i),
  .bus_rd    (bus_rd_i),
  .bus_wdata (bus_wdata_i),
  .rdata     (bus_rdata_o),
  .rvalid    (bus_rvalid_o),
  .per_wmask (per_wmask_i),
  .reg_q     (reg_q_o),
  .sts       (sts_i),
  .cmd_valid (cmd_valid_o),
  .cmd_data  (cmd_data_o),
  .raz_mask  (raz_mask),
  .ro_mask   (ro_mask)
);

// File: tb/test_csr_policy_reg.sv
module test_csr_policy_reg;

  localparam logic [31:0] RST_V   = 32'h096003A5;
  localparam logic [31:0] BUS_M   = 32'h00FF00FF; // R2 bus-writable bits
  localparam logic [31:0] PER_M   = 32'h00FF0FFF; // R7 peripheral-writable bits
  localparam logic [31:0] STS_V   = 32'hCAFE1234;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, per_wmask, per_wdata, sts;
  logic [31:0] rdata, reg_q, cmd_data;
  logic        rvalid, cmd_valid;
  logic [31:0] rdata_a, reg_q_a, cmd_data_a;
  logic        rvalid_a, cmd_valid_a;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] exp_q, exp_a;

  always #10 clk = ~clk;

  csr_policy_reg i_csr_policy_reg (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .per_wmask_i(per_wmask), .per_wdata_i(per_wdata), .reg_q_o(reg_q),
    .sts_i(sts), .cmd_valid_o(cmd_valid), .cmd_data_o(cmd_data));

  csr_policy_reg #(.ALIAS(1'b1)) i_csr_policy_reg_alias (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata_a), .bus_rvalid_o(rvalid_a),
    .per_wmask_i(per_wmask), .per_wdata_i(per_wdata), .reg_q_o(reg_q_a),
    .sts_i(sts), .cmd_valid_o(cmd_valid_a), .cmd_data_o(cmd_data_a));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus/peripheral cycle, then compare against the model on the next negedge.
  task automatic op(input logic wr, input logic rd, input logic [31:0] wd,
                    input logic [31:0] m, input logic [31:0] pd);
    logic [31:0] pre_q;
    pre_q = exp_q;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_wdata = wd; per_wmask = m; per_wdata = pd;
    if (wr) exp_q = (exp_q & ~BUS_M) | (wd & BUS_M);
    exp_q = (exp_q & ~(m & PER_M)) | (pd & m & PER_M);
    exp_a = (exp_a & ~(m & PER_M)) | (pd & m & PER_M);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; per_wmask = '0; per_wdata = '0;
    chk("R7 model reg_q", reg_q, exp_q);
    chk("R10 alias fields", reg_q_a, exp_a);
    if (rd) begin
      chk("R9 rvalid", {31'd0, rvalid}, 32'd1);
      chk("R9 rdata pre-write", rdata, pre_q);
      chk("R11 alias rdata", rdata_a, STS_V);
    end
    if (wr) begin
      chk("R10 cmd_valid", {31'd0, cmd_valid_a}, 32'd1);
      chk("R10 cmd_data", cmd_data_a, wd);
    end
  endtask

  task automatic t_reset;
    chk("R1 reset reg_q", reg_q, RST_V);
    chk("R1 alias reset reg_q", reg_q_a, RST_V);
    chk("R9 rvalid idle", {31'd0, rvalid}, 32'd0);
    op(1'b0, 1'b1, '0, '0, '0);
    chk("R1 reset read", rdata, RST_V);
  endtask

  task automatic t_bus_all;
    op(1'b1, 1'b0, 32'hFFFFFFFF, '0, '0);
    chk("R2 whole word", reg_q, 32'h09FF03FF);
    chk("R3 ro ignores bus", {28'd0, reg_q[11:8]}, 32'h3);
    chk("R4 raz zero", {28'd0, reg_q[15:12]}, 32'h0);
    chk("R5 w0 store", {28'd0, reg_q[19:16]}, 32'hF);
    chk("R5 w0 stateless", {28'd0, reg_q[31:28]}, 32'h0);
    chk("R6 wl store", {28'd0, reg_q[23:20]}, 32'hF);
    chk("R6 wl stateless", {28'd0, reg_q[27:24]}, 32'h9);
    chk("R10 alias unchanged", reg_q_a, RST_V);
    @(negedge clk);
    chk("R10 cmd one cycle", {31'd0, cmd_valid_a}, 32'd0);
    op(1'b1, 1'b0, 32'h12345678, '0, '0);
    chk("R2 second word", reg_q, 32'h09340378);
    op(1'b0, 1'b1, '0, '0, '0);
    chk("R2 read back", rdata, 32'h09340378);
  endtask

  task automatic t_per;
    op(1'b0, 1'b0, '0, 32'h0000F0F0, 32'hFFFFFFFF);
    chk("R7 masked bits", reg_q, 32'h093403F8);
    chk("R4 raz ignores peripheral", {28'd0, reg_q[15:12]}, 32'h0);
    op(1'b0, 1'b0, '0, 32'h00000F00, 32'h00000500);
    chk("R3 ro via peripheral", {28'd0, reg_q[11:8]}, 32'h5);
    chk("R10 alias per write", reg_q_a, 32'h096005F5);
  endtask

  task automatic t_collide;
    op(1'b1, 1'b0, 32'h00AA00AA, 32'h0000000F, 32'h00000005);
    chk("R8 collision word", reg_q, 32'h09AA05A5);
    chk("R8 per wins low nibble", {28'd0, reg_q[3:0]}, 32'h5);
    chk("R8 bus lands high nibble", {28'd0, reg_q[7:4]}, 32'hA);
  endtask

  task automatic t_rd_wr;
    op(1'b1, 1'b1, 32'h00000000, '0, '0);
    chk("R9 read before write", rdata, 32'h09AA05A5);
    chk("R9 write landed", reg_q, 32'h09000500);
    chk("R11 no written word", rdata_a, STS_V);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; per_wmask = '0; per_wdata = '0; sts = STS_V;
    exp_q = RST_V; exp_a = RST_V;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bus_all();
    t_per();
    t_collide();
    t_rd_wr();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule